// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This peripheral holds three reloadable down-counters and one wide up-counting free-running counter behind a small word-addressed register bus. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Each channel counts down on a tick it selects: either a slow tick input or a fast tick input. When a channel passes through zero it flags a pending interrupt. That interrupt stays raised until software writes to the channel's clear register. In periodic mode a channel reloads from its load register when it passes zero. In free mode it wraps to its all-ones value.

The fourth counter is 40 bits wide and counts up on the fast tick only. Bit 8 of its high register enables it, and it never interrupts. Software reads its lower 32 bits from one register and its top byte from another. The two tick inputs are one-cycle enables that stand for the two reference clocks. Clock generation and prescaling are done elsewhere.

Top module: `tmr_quad_unit`

## Requirements
- R1: After reset every readable register returns zero and all three interrupt outputs are low.
- R2: When a write to a channel's control register changes its enable bit (bit 7) from 0 to 1, the channel's value becomes its load register in the following cycle.
- R3: A periodic channel (bit 6 set) with load value N-1 passes zero once every N selected ticks. After that many ticks it shows N-1 again, and its interrupt goes high on the tick that leaves zero.
- R4: A channel in free mode (bit 6 clear) steps from zero to its all-ones value (0xFFFF for 16-bit channels, 0xFFFFFFFF for channel 2) and still raises its interrupt.
- R5: Any write to a channel's clear register drops that channel's interrupt and no other. If a zero crossing happens in the same cycle as the clear, the interrupt stays set.
- R6: While the enable bit is 0 the channel's value holds whatever the ticks do.
- R7: Control bit 3 set makes the channel count on the slow tick, and bit 3 clear makes it count on the fast tick. The other tick has no effect.
- R8: Writing the load register of an enabled channel also replaces its value on the next clock. Writing the load register of a disabled channel leaves the value unchanged.
- R9: The wide counter is enabled by writing 1 to bit 8 of its high register. While enabled it adds one per fast tick and ignores the slow tick. Writing 0 to bit 8 stops it and clears it to zero. Reading the high register returns the enable at bit 8 and counter bits 39..32 in bits 7..0. Reading the low register returns counter bits 31..0.
- R10: The register map uses word indices. For channel c (c = 0, 1, 2), the index c*4+0 holds the load register (read/write), c*4+1 the value (read-only, zero-extended, writes ignored), c*4+2 the control register and c*4+3 the clear register (write-only, reads zero). Index 12 holds the wide counter's low register and index 13 its high register. Control reads return only bits 7, 6 and 3; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | Slow reference tick enable |
| tick_fast | input | 1 | Fast reference tick enable |
| bus_addr | input | ADDR_W | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 3 | Pending interrupt per down-counting channel |

## Verification
The hardest state to reach from the ports is a clear write that lands in the same cycle as a zero crossing. The stimulus sets up a periodic channel with load 0, so every selected tick is a crossing. It then raises the slow tick and the clear write in the same cycle and checks that the interrupt survives. Exact reload behaviour is checked with sweeps: for several small load values, the expected value after each tick is computed as (N-1) - (t mod N). The same arithmetic also predicts when the interrupt appears.

// File: rtl/tmr_quad_pkg.sv
package tmr_quad_pkg;

   localparam int CH_N        = 3;
   localparam int CH_STRIDE   = 4;
   localparam int OFS_LOAD    = 0;
   localparam int OFS_VAL     = 1;
   localparam int OFS_CTRL    = 2;
   localparam int OFS_CLR     = 3;
   localparam int WIDE_LO_IDX = 12;
   localparam int WIDE_HI_IDX = 13;

   localparam int CTL_EN_BIT   = 7;
   localparam int CTL_PER_BIT  = 6;
   localparam int CTL_SLOW_BIT = 3;
   localparam int WIDE_EN_BIT  = 8;

   typedef struct packed {
      logic en;
      logic periodic;
      logic slow;
   } ch_ctrl_t;

   function automatic int ch_reg_idx(input int ch, input int ofs);
      return ch * CH_STRIDE + ofs;
   endfunction

endpackage

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
   import tmr_quad_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int NCH    = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output logic [NCH-1:0]    wr_load,
   output logic [NCH-1:0]    wr_ctrl,
   output logic [NCH-1:0]    wr_clear,
   output logic              wr_wide_hi
);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] IDX_LD  = ADDR_W'(ch_reg_idx(c, OFS_LOAD));
      localparam logic [ADDR_W-1:0] IDX_CT  = ADDR_W'(ch_reg_idx(c, OFS_CTRL));
      localparam logic [ADDR_W-1:0] IDX_CL  = ADDR_W'(ch_reg_idx(c, OFS_CLR));
      assign wr_load[c]  = we && (addr == IDX_LD);
      assign wr_ctrl[c]  = we && (addr == IDX_CT);
      assign wr_clear[c] = we && (addr == IDX_CL);
   end

   assign wr_wide_hi = we && (addr == ADDR_W'(WIDE_HI_IDX));

endmodule

// File: rtl/tmr_downcnt.sv
module tmr_downcnt
   import tmr_quad_pkg::*;
#(
   parameter int W      = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_slow,
   input  logic              tick_fast,
   input  logic              wr_load,
   input  logic              wr_ctrl,
   input  logic              wr_clear,
   input  logic [DATA_W-1:0] wdata,
   output ch_ctrl_t          ctrl_q,
   output logic [DATA_W-1:0] load_rd,
   output logic [DATA_W-1:0] val_rd,
   output logic              irq_q
);

   logic [W-1:0] load_q;
   logic [W-1:0] val_q;
   logic [W-1:0] wr_val;
   logic         tick_hit;
   logic         at_zero;
   logic         en_rise;
   logic         underflow;
   logic         unused_wdata;

   assign wr_val       = wdata[W-1:0];
   assign unused_wdata = ^wdata;

   // Tick source picked by the select bit: set = slow, clear = fast.
   assign tick_hit  = ctrl_q.slow ? tick_slow : tick_fast;
   assign at_zero   = (val_q == '0);
   assign en_rise   = wr_ctrl && wdata[CTL_EN_BIT] && !ctrl_q.en;
   // A load write on a running channel overrides the step of that cycle.
   assign underflow = ctrl_q.en && tick_hit && at_zero && !wr_load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
         val_q  <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.en       <= wdata[CTL_EN_BIT];
            ctrl_q.periodic <= wdata[CTL_PER_BIT];
            ctrl_q.slow     <= wdata[CTL_SLOW_BIT];
         end

         if (wr_load)
            load_q <= wr_val;

         if (en_rise)
            val_q <= load_q;
         else if (wr_load && ctrl_q.en)
            val_q <= wr_val;
         else if (ctrl_q.en && tick_hit) begin
            if (at_zero)
               val_q <= ctrl_q.periodic ? load_q : '1;
            else
               val_q <= val_q - 1'b1;
         end

         // Set wins over a clear in the same cycle.
         if (underflow)
            irq_q <= 1'b1;
         else if (wr_clear)
            irq_q <= 1'b0;
      end
   end

   if (W == DATA_W) begin : g_full
      assign load_rd = load_q;
      assign val_rd  = val_q;
   end else begin : g_pad
      assign load_rd = {{(DATA_W-W){1'b0}}, load_q};
      assign val_rd  = {{(DATA_W-W){1'b0}}, val_q};
   end

endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun
   import tmr_quad_pkg::*;
#(
   parameter int WIDE_W = 40,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_fast,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [WIDE_W-1:0] cnt_q,
   output logic              en_q,
   output logic [DATA_W-1:0] rd_lo,
   output logic [DATA_W-1:0] rd_hi
);

   localparam int HI_W = WIDE_W - DATA_W;

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else begin
         if (wr_hi)
            en_q <= wdata[WIDE_EN_BIT];

         if (wr_hi && !wdata[WIDE_EN_BIT])
            cnt_q <= '0;
         else if (en_q && tick_fast)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign rd_lo = cnt_q[DATA_W-1:0];

   always_comb begin
      rd_hi              = '0;
      rd_hi[HI_W-1:0]    = cnt_q[WIDE_W-1:DATA_W];
      rd_hi[WIDE_EN_BIT] = en_q;
   end

endmodule

// File: rtl/tmr_quad_unit.sv
module tmr_quad_unit
   import tmr_quad_pkg::*;
#(
   parameter int CH0_W  = 16,
   parameter int CH1_W  = 16,
   parameter int CH2_W  = 32,
   parameter int WIDE_W = 40,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_slow,
   input  logic              tick_fast,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [2:0]        irq
);

   // Elaboration-time parameter checks
   if (DATA_W < WIDE_EN_BIT + 1) begin : g_bad_data
      $error("DATA_W too narrow for control fields");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover word index 13");
   end
   if (CH0_W < 1 || CH0_W > DATA_W || CH1_W < 1 || CH1_W > DATA_W ||
       CH2_W < 1 || CH2_W > DATA_W) begin : g_bad_ch
      $error("channel width out of range");
   end
   if (WIDE_W <= DATA_W || WIDE_W > DATA_W + WIDE_EN_BIT) begin : g_bad_wide
      $error("WIDE_W must exceed DATA_W by 1..8 bits");
   end

   logic [CH_N-1:0]              wr_load;
   logic [CH_N-1:0]              wr_ctrl;
   logic [CH_N-1:0]              wr_clear;
   logic                         wr_wide_hi;
   logic [CH_N-1:0][DATA_W-1:0]  ch_val_w;
   logic [CH_N-1:0][DATA_W-1:0]  ch_load_w;
   logic [CH_N-1:0][DATA_W-1:0]  ch_ctrl_rd;
   logic [CH_N-1:0]              ch_en_w;
   logic [WIDE_W-1:0]            wide_cnt;
   logic                         wide_en;
   logic [DATA_W-1:0]            wide_lo_rd;
   logic [DATA_W-1:0]            wide_hi_rd;

   tmr_bus_dec #(.ADDR_W(ADDR_W), .NCH(CH_N)) u_dec (
      .addr       (bus_addr),
      .we         (bus_we),
      .wr_load    (wr_load),
      .wr_ctrl    (wr_ctrl),
      .wr_clear   (wr_clear),
      .wr_wide_hi (wr_wide_hi)
   );

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      localparam int CW = (c == 0) ? CH0_W : (c == 1) ? CH1_W : CH2_W;
      ch_ctrl_t ctl;

      tmr_downcnt #(.W(CW), .DATA_W(DATA_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_slow (tick_slow),
         .tick_fast (tick_fast),
         .wr_load   (wr_load[c]),
         .wr_ctrl   (wr_ctrl[c]),
         .wr_clear  (wr_clear[c]),
         .wdata     (bus_wdata),
         .ctrl_q    (ctl),
         .load_rd   (ch_load_w[c]),
         .val_rd    (ch_val_w[c]),
         .irq_q     (irq[c])
      );

      assign ch_en_w[c] = ctl.en;

      always_comb begin
         ch_ctrl_rd[c]               = '0;
         ch_ctrl_rd[c][CTL_EN_BIT]   = ctl.en;
         ch_ctrl_rd[c][CTL_PER_BIT]  = ctl.periodic;
         ch_ctrl_rd[c][CTL_SLOW_BIT] = ctl.slow;
      end
   end

   tmr_freerun #(.WIDE_W(WIDE_W), .DATA_W(DATA_W)) u_wide (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_fast (tick_fast),
      .wr_hi     (wr_wide_hi),
      .wdata     (bus_wdata),
      .cnt_q     (wide_cnt),
      .en_q      (wide_en),
      .rd_lo     (wide_lo_rd),
      .rd_hi     (wide_hi_rd)
   );

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < CH_N; c++) begin
         if (bus_addr == ADDR_W'(ch_reg_idx(c, OFS_LOAD)))
            bus_rdata = ch_load_w[c];
         if (bus_addr == ADDR_W'(ch_reg_idx(c, OFS_VAL)))
            bus_rdata = ch_val_w[c];
         if (bus_addr == ADDR_W'(ch_reg_idx(c, OFS_CTRL)))
            bus_rdata = ch_ctrl_rd[c];
      end
      if (bus_addr == ADDR_W'(WIDE_LO_IDX))
         bus_rdata = wide_lo_rd;
      if (bus_addr == ADDR_W'(WIDE_HI_IDX))
         bus_rdata = wide_hi_rd;
   end

endmodule

// File: rtl/tmr_quad_unit_chk.sv
module tmr_quad_unit_chk
   import tmr_quad_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int WIDE_W = 40
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        tick_fast,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic                        bus_we,
   input logic [2:0]                  irq,
   input logic [CH_N-1:0][DATA_W-1:0] ch_val,
   input logic [CH_N-1:0]             ch_en,
   input logic [WIDE_W-1:0]           wide_cnt,
   input logic                        wide_en
);

   logic hi_wr;
   assign hi_wr = bus_we && (bus_addr == ADDR_W'(WIDE_HI_IDX));

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      logic clr_wr;
      logic ctl_wr;
      assign clr_wr = bus_we && (bus_addr == ADDR_W'(ch_reg_idx(c, OFS_CLR)));
      assign ctl_wr = bus_we && (bus_addr == ADDR_W'(ch_reg_idx(c, OFS_CTRL)));

      // R5: pending interrupt persists until its own clear register is written
      a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         irq[c] && !clr_wr |=> irq[c]);

      // R6: a disabled channel holds its value unless its control is written
      a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[c] && !ctl_wr |=> $stable(ch_val[c]));

      // R3: an interrupt only appears after the value sat at zero
      a_r3_irq_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[c]) |-> $past(ch_val[c]) == '0);
   end

   // R9: while running, the wide counter advances by at most one per cycle
   a_r9_wide_step: assert property (@(posedge clk) disable iff (!rst_n)
      wide_en && $past(wide_en) |->
         (wide_cnt == $past(wide_cnt)) || (wide_cnt == $past(wide_cnt) + 1'b1));

   // R9: without a fast tick and without a high-register write it holds
   a_r9_slow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      wide_en && !tick_fast && !hi_wr |=> $stable(wide_cnt));

endmodule

bind tmr_quad_unit tmr_quad_unit_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .WIDE_W (WIDE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_fast (tick_fast),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .irq       (irq),
   .ch_val    (ch_val_w),
   .ch_en     (ch_en_w),
   .wide_cnt  (wide_cnt),
   .wide_en   (wide_en)
);

// File: tb/tmr_quad_unit_tb.sv
module tmr_quad_unit_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_slow = 1'b0;
   logic        tick_fast = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] rv;

   tmr_quad_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int ra(input int ch, input int ofs);
      return ch * 4 + ofs;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = 4'(a);
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 4'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse_slow(input int n);
      repeat (n) begin
         @(negedge clk);
         tick_slow = 1'b1;
         @(negedge clk);
         tick_slow = 1'b0;
      end
   endtask

   task automatic pulse_fast(input int n);
      repeat (n) begin
         @(negedge clk);
         tick_fast = 1'b1;
         @(negedge clk);
         tick_fast = 1'b0;
      end
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state over all indices
      for (int a = 0; a < 16; a++) begin
         rd(a, rv);
         check("R1 reset register", rv, 32'h0);
      end
      check("R1 reset irq", {29'h0, irq}, 32'h0);

      // R3/R2: periodic sweep on channel 0 for N = 1..6
      for (int n = 1; n <= 6; n++) begin
         wr(ra(0, 2), 32'h48);
         wr(ra(0, 0), 32'(n - 1));
         wr(ra(0, 2), 32'hC8);
         wr(ra(0, 3), 32'h0);
         rd(ra(0, 1), rv);
         check("R2 enable copies load", rv, 32'(n - 1));
         for (int t = 1; t <= 2 * n + 1; t++) begin
            pulse_slow(1);
            rd(ra(0, 1), rv);
            check("R3 periodic value", rv, 32'((n - 1) - (t % n)));
            check("R3 irq timing", {31'h0, irq[0]}, {31'h0, (t >= n)});
         end
      end

      // R3: channel 2 (32-bit) periodic sweep
      for (int n = 2; n <= 8; n += 3) begin
         wr(ra(2, 2), 32'h48);
         wr(ra(2, 0), 32'(n - 1));
         wr(ra(2, 2), 32'hC8);
         wr(ra(2, 3), 32'h0);
         for (int t = 1; t <= n + 2; t++) begin
            pulse_slow(1);
            rd(ra(2, 1), rv);
            check("R3 ch2 periodic value", rv, 32'((n - 1) - (t % n)));
         end
         check("R3 ch2 irq", {31'h0, irq[2]}, 32'h1);
      end

      // R7: channel 1 on fast tick ignores slow tick
      wr(ra(1, 2), 32'h48);
      wr(ra(1, 0), 32'd4);
      wr(ra(1, 2), 32'hC0);
      pulse_slow(3);
      rd(ra(1, 1), rv);
      check("R7 slow ignored in fast mode", rv, 32'd4);
      rd(ra(0, 1), rv);
      begin
         logic [31:0] ch0_before;
         ch0_before = rv;
         pulse_fast(2);
         rd(ra(1, 1), rv);
         check("R7 fast tick counts", rv, 32'd2);
         rd(ra(0, 1), rv);
         check("R7 slow-mode channel ignores fast", rv, ch0_before);
      end

      // R4: free mode wraps to all ones
      wr(ra(1, 2), 32'h08);
      wr(ra(1, 3), 32'h0);
      wr(ra(1, 0), 32'd2);
      wr(ra(1, 2), 32'h88);
      pulse_slow(3);
      rd(ra(1, 1), rv);
      check("R4 16-bit wrap", rv, 32'h0000_FFFF);
      check("R4 irq on wrap", {31'h0, irq[1]}, 32'h1);
      pulse_slow(1);
      rd(ra(1, 1), rv);
      check("R4 continues after wrap", rv, 32'h0000_FFFE);
      wr(ra(2, 2), 32'h08);
      wr(ra(2, 0), 32'd0);
      wr(ra(2, 2), 32'h88);
      pulse_slow(1);
      rd(ra(2, 1), rv);
      check("R4 32-bit wrap", rv, 32'hFFFF_FFFF);

      // R5: clear only affects own channel; any data clears
      wr(ra(0, 3), 32'h0);
      check("R5 other clear leaves irq1", {31'h0, irq[1]}, 32'h1);
      wr(ra(1, 3), 32'hDEAD_0000);
      check("R5 own clear drops irq1", {31'h0, irq[1]}, 32'h0);

      // R5: clear in same cycle as zero crossing keeps irq set
      wr(ra(1, 2), 32'h48);
      wr(ra(1, 0), 32'd0);
      wr(ra(1, 2), 32'hC8);
      wr(ra(1, 3), 32'h0);
      @(negedge clk);
      tick_slow = 1'b1;
      bus_addr  = 4'(ra(1, 3));
      bus_wdata = 32'h0;
      bus_we    = 1'b1;
      @(negedge clk);
      tick_slow = 1'b0;
      bus_we    = 1'b0;
      check("R5 set wins over clear", {31'h0, irq[1]}, 32'h1);
      wr(ra(1, 3), 32'h0);
      check("R5 clear after collision", {31'h0, irq[1]}, 32'h0);

      // R6: disabled channel holds value
      wr(ra(0, 2), 32'h48);
      wr(ra(0, 0), 32'd9);
      wr(ra(0, 2), 32'hC8);
      pulse_slow(3);
      rd(ra(0, 1), rv);
      check("R3 count before freeze", rv, 32'd6);
      wr(ra(0, 2), 32'h48);
      pulse_slow(4);
      pulse_fast(2);
      rd(ra(0, 1), rv);
      check("R6 frozen while disabled", rv, 32'd6);
      wr(ra(0, 2), 32'hC8);
      rd(ra(0, 1), rv);
      check("R2 re-enable reloads", rv, 32'd9);

      // R8: load write while running / while disabled
      wr(ra(0, 0), 32'd20);
      rd(ra(0, 1), rv);
      check("R8 running load updates value", rv, 32'd20);
      pulse_slow(1);
      rd(ra(0, 1), rv);
      check("R8 counts from new load", rv, 32'd19);
      wr(ra(0, 2), 32'h48);
      wr(ra(0, 0), 32'd5);
      rd(ra(0, 1), rv);
      check("R8 disabled load keeps value", rv, 32'd19);
      wr(ra(0, 2), 32'hC8);
      rd(ra(0, 1), rv);
      check("R2 enable picks new load", rv, 32'd5);

      // R10: readback masks, read-only value, write-only clear
      wr(ra(2, 2), 32'hFFFF_FFFF);
      rd(ra(2, 2), rv);
      check("R10 control readback mask", rv, 32'h0000_00C8);
      wr(ra(0, 1), 32'h1234);
      rd(ra(0, 1), rv);
      check("R10 value write ignored", rv, 32'd5);
      rd(ra(0, 0), rv);
      check("R10 load readback", rv, 32'd5);
      rd(ra(0, 3), rv);
      check("R10 clear reads zero", rv, 32'h0);
      wr(ra(1, 0), 32'hABCD_1234);
      rd(ra(1, 0), rv);
      check("R10 16-bit load zero-extended", rv, 32'h0000_1234);

      // R9: wide counter
      pulse_fast(3);
      rd(12, rv);
      check("R9 disabled wide stays zero", rv, 32'h0);
      wr(13, 32'h100);
      rd(13, rv);
      check("R9 high register enable bit", rv, 32'h100);
      pulse_fast(5);
      rd(12, rv);
      check("R9 counts fast ticks", rv, 32'd5);
      pulse_slow(3);
      rd(12, rv);
      check("R9 slow tick ignored", rv, 32'd5);
      rd(13, rv);
      check("R9 high byte zero", rv, 32'h100);
      wr(13, 32'h0);
      rd(12, rv);
      check("R9 disable clears low", rv, 32'h0);
      rd(13, rv);
      check("R9 disable clears high", rv, 32'h0);

      finish_run();
   end

endmodule